// File: doc/BRIEF.md
# Aligned Power-of-Two Entry Allocator

This block keeps one occupancy bit for every slot of a remapping table and hands out groups of slots on request. A group always holds a power-of-two number of slots and starts at a multiple of its own size. The caller asks for a number of slots. The block rounds that number up to the next power of two and checks the resulting size exponent against a limit the caller programs. It then searches the table for the first fully vacant group, claims it, and returns where the group starts together with the exponent.

The block serves one operation at a time. A request is taken only while the block is idle. The search examines one candidate group per clock. It always starts at slot 0 and moves forward in steps of one group size, and it gives up once the candidate position wraps back to 0. A release operation takes a start slot and an exponent and clears the matching slots in a single cycle. Every operation ends with a one-cycle completion pulse that carries a success flag.

Top module: `grp_alloc`

## Requirements
- R1: A request with a count of 0 fails. `done_o` pulses one cycle after acceptance with `ok_o`=0, and no occupancy bit changes.
- R2: A count of 1 gives exponent 0. A larger count gives the smallest exponent m with 2^m >= count. The exponent is returned on `mask_o` when the request succeeds.
- R3: When the exponent is greater than `max_mask_i`, the request fails one cycle after acceptance. No search takes place and no occupancy bit changes.
- R4: When the rounded group size is larger than the table, the request fails one cycle after acceptance.
- R5: The search begins at slot 0 on every request and moves in steps of the rounded size. The result is the lowest candidate whose slots are all vacant, so `index_o` is always a multiple of 2^`mask_o`.
- R6: One candidate is examined per clock. When k candidates are examined, `done_o` rises k cycles after the cycle that accepted the request.
- R7: When the next candidate position, taken modulo the table size, comes back to 0, the request fails with `ok_o`=0.
- R8: A successful request marks every slot of its group occupied. Later requests skip those slots.
- R9: A release (`free_valid_i` while idle and `req_valid_i` low) clears 2^`free_mask_i` slots starting at `free_base_i`. Slots past the table end are left alone. `done_o` pulses the next cycle with `ok_o`=1, `index_o`=`free_base_i` and `mask_o`=`free_mask_i`.
- R10: A release is ignored when it arrives in the same cycle as a request, or while the block is busy.
- R11: `done_o` is high for exactly one cycle per operation. `busy_o` is high from the cycle after a request is accepted until a search result is produced, and it is low while `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; clears every occupancy bit |
| max_mask_i | input | MASK_W | Largest size exponent a request may use |
| req_valid_i | input | 1 | Start an allocation (sampled while idle) |
| req_count_i | input | CNT_W | Number of slots requested |
| free_valid_i | input | 1 | Start a release (sampled while idle) |
| free_base_i | input | IDX_W | First slot to release |
| free_mask_i | input | MASK_W | Size exponent of the release |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ok_o | output | 1 | 1 = success, valid with done_o |
| index_o | output | IDX_W | Start slot of the group, valid with done_o |
| mask_o | output | MASK_W | Size exponent, valid with done_o |

## Verification
Some properties can be checked on every cycle from the ports alone. The assertions cover the single-cycle completion pulse and the rule that busy and done are never high together. They also check that a count of zero, a count above the programmed limit, or a group larger than the table each fails in the very next cycle, and that every successful result is aligned to its own size. Other behaviour depends on the contents of the occupancy table, which the assertions do not track. The bench scenarios cover this part with their own occupancy model: which slot the search picks, how many cycles it takes, the failure after wrapping, the effect of releases, and the release that is dropped when a request arrives in the same cycle.

// File: rtl/grp_alloc_pkg.sv
package grp_alloc_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } alloc_state_e;

endpackage

// File: rtl/grp_size_calc.sv
module grp_size_calc #(
    parameter int CNT_W  = 7,
    parameter int MASK_W = 3
) (
    input  logic [CNT_W-1:0]  count_i,
    output logic [MASK_W-1:0] mask_o
);
    always_comb begin
        mask_o = '0;
        for (int k = 0; k < CNT_W; k++) begin
            if (32'(count_i) > (32'd1 << k)) begin
                mask_o = MASK_W'(k + 1);
            end
        end
    end
endmodule

// File: rtl/grp_span_mask.sv
module grp_span_mask #(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = 6,
    parameter int MASK_W  = 3
) (
    input  logic [IDX_W-1:0]   base_i,
    input  logic [MASK_W-1:0]  mask_i,
    output logic [ENTRIES-1:0] span_o
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        assign span_o[g] = (32'(g) >= 32'(base_i)) &&
                           ((32'(g) - 32'(base_i)) < (32'd1 << mask_i));
    end
endmodule

// File: rtl/grp_alloc.sv
module grp_alloc
    import grp_alloc_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = $clog2(ENTRIES),
    parameter int CNT_W   = IDX_W + 1,
    parameter int MASK_W  = $clog2(CNT_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MASK_W-1:0] max_mask_i,
    input  logic              req_valid_i,
    input  logic [CNT_W-1:0]  req_count_i,
    input  logic              free_valid_i,
    input  logic [IDX_W-1:0]  free_base_i,
    input  logic [MASK_W-1:0] free_mask_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              ok_o,
    output logic [IDX_W-1:0]  index_o,
    output logic [MASK_W-1:0] mask_o
);
    typedef struct packed {
        alloc_state_e        state;
        logic [ENTRIES-1:0]  present;
        logic [IDX_W-1:0]    cand;
        logic [MASK_W-1:0]   mask;
        logic                done;
        logic                ok;
        logic [IDX_W-1:0]    index;
        logic [MASK_W-1:0]   res_mask;
    } alloc_regs_t;

    alloc_regs_t r_d, r_q;

    logic [MASK_W-1:0]  req_mask;
    logic [ENTRIES-1:0] cand_span;
    logic [ENTRIES-1:0] free_span;
    logic [IDX_W-1:0]   cand_next;
    logic               req_oversize;

    grp_size_calc #(.CNT_W(CNT_W), .MASK_W(MASK_W)) u_size (
        .count_i (req_count_i),
        .mask_o  (req_mask)
    );

    grp_span_mask #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .MASK_W(MASK_W)) u_cand_span (
        .base_i (r_q.cand),
        .mask_i (r_q.mask),
        .span_o (cand_span)
    );

    grp_span_mask #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .MASK_W(MASK_W)) u_free_span (
        .base_i (free_base_i),
        .mask_i (free_mask_i),
        .span_o (free_span)
    );

    assign req_oversize = 32'(req_mask) > 32'(IDX_W);
    assign cand_next    = r_q.cand + IDX_W'(32'd1 << r_q.mask);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (req_valid_i) begin
                    if ((req_count_i == '0) || req_oversize || (req_mask > max_mask_i)) begin
                        r_d.done     = 1'b1;
                        r_d.ok       = 1'b0;
                        r_d.index    = '0;
                        r_d.res_mask = req_mask;
                    end else begin
                        r_d.state = ST_SCAN;
                        r_d.cand  = '0;
                        r_d.mask  = req_mask;
                    end
                end else if (free_valid_i) begin
                    r_d.present  = r_q.present & ~free_span;
                    r_d.done     = 1'b1;
                    r_d.ok       = 1'b1;
                    r_d.index    = free_base_i;
                    r_d.res_mask = free_mask_i;
                end
            end
            ST_SCAN: begin
                if ((r_q.present & cand_span) == '0) begin
                    r_d.present  = r_q.present | cand_span;
                    r_d.done     = 1'b1;
                    r_d.ok       = 1'b1;
                    r_d.index    = r_q.cand;
                    r_d.res_mask = r_q.mask;
                    r_d.state    = ST_IDLE;
                end else if (cand_next == '0) begin
                    r_d.done     = 1'b1;
                    r_d.ok       = 1'b0;
                    r_d.index    = '0;
                    r_d.res_mask = r_q.mask;
                    r_d.state    = ST_IDLE;
                end else begin
                    r_d.cand = cand_next;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o  = (r_q.state == ST_SCAN);
    assign done_o  = r_q.done;
    assign ok_o    = r_q.ok;
    assign index_o = r_q.index;
    assign mask_o  = r_q.res_mask;
endmodule

// File: rtl/grp_alloc_chk.sv
module grp_alloc_chk #(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = 6,
    parameter int CNT_W   = 7,
    parameter int MASK_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [MASK_W-1:0] max_mask_i,
    input logic              req_valid_i,
    input logic [CNT_W-1:0]  req_count_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              ok_o,
    input logic [IDX_W-1:0]  index_o,
    input logic [MASK_W-1:0] mask_o
);
    logic accept;
    assign accept = !busy_o && req_valid_i;

    assert_zero_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
        accept && (req_count_i == '0) |=> done_o && !ok_o);

    assert_over_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        accept && (32'(req_count_i) > (32'd1 << max_mask_i)) |=> done_o && !ok_o);

    assert_over_table_R4: assert property (@(posedge clk) disable iff (!rst_n)
        accept && (32'(req_count_i) > 32'(ENTRIES)) |=> done_o && !ok_o);

    assert_aligned_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && ok_o && !$past(!busy_o && !req_valid_i) |->
            ((32'(index_o) & ((32'd1 << mask_o) - 32'd1)) == 32'd0));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_not_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
endmodule

bind grp_alloc grp_alloc_chk #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W), .CNT_W(CNT_W), .MASK_W(MASK_W)
) u_grp_alloc_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .max_mask_i  (max_mask_i),
    .req_valid_i (req_valid_i),
    .req_count_i (req_count_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .ok_o        (ok_o),
    .index_o     (index_o),
    .mask_o      (mask_o)
);

// File: tb/grp_alloc_bench.sv
module grp_alloc_bench;
    localparam int ENTRIES = 64;
    localparam int IDX_W   = 6;
    localparam int CNT_W   = 7;
    localparam int MASK_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [MASK_W-1:0] max_mask_i = 3'd6;
    logic              req_valid_i = 1'b0;
    logic [CNT_W-1:0]  req_count_i = '0;
    logic              free_valid_i = 1'b0;
    logic [IDX_W-1:0]  free_base_i = '0;
    logic [MASK_W-1:0] free_mask_i = '0;
    logic              busy_o, done_o, ok_o;
    logic [IDX_W-1:0]  index_o;
    logic [MASK_W-1:0] mask_o;

    int checks = 0;
    int fails  = 0;
    bit [ENTRIES-1:0] mdl = '0;

    always #4 clk = ~clk;

    grp_alloc #(.ENTRIES(ENTRIES)) u_grp_alloc (
        .clk(clk), .rst_n(rst_n), .max_mask_i(max_mask_i),
        .req_valid_i(req_valid_i), .req_count_i(req_count_i),
        .free_valid_i(free_valid_i), .free_base_i(free_base_i), .free_mask_i(free_mask_i),
        .busy_o(busy_o), .done_o(done_o), .ok_o(ok_o), .index_o(index_o), .mask_o(mask_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Wait for done_o, counting extra cycles; busy must be high meanwhile (R11)
    task automatic wait_done(output int waits);
        waits = 0;
        while (!done_o && waits < 200) begin
            check("R11", "busy during search", int'(busy_o), 1);
            @(negedge clk);
            waits++;
        end
    endtask

    task automatic alloc(input int cnt, input string req, input bit with_free = 0,
                         input int fbase = 0, input int fmask = 0);
        int m, idx, tries, waits, size;
        bit ok;
        m = 0;
        for (int k = 0; k < CNT_W; k++) if (cnt > (1 << k)) m = k + 1;
        size = 1 << m;
        ok = 0; idx = 0; tries = 0;
        if (cnt != 0 && m <= IDX_W && m <= int'(max_mask_i)) begin
            for (int t = 0; t < ENTRIES + 1; t++) begin
                bit vacant;
                vacant = 1;
                tries++;
                for (int s = idx; s < idx + size; s++) if (mdl[s]) vacant = 0;
                if (vacant) begin
                    ok = 1;
                    for (int s = idx; s < idx + size; s++) mdl[s] = 1'b1;
                    break;
                end
                idx = (idx + size) % ENTRIES;
                if (idx == 0) break;
            end
        end
        req_valid_i  = 1'b1;
        req_count_i  = CNT_W'(cnt);
        free_valid_i = with_free;
        free_base_i  = IDX_W'(fbase);
        free_mask_i  = MASK_W'(fmask);
        @(negedge clk);
        req_valid_i  = 1'b0;
        free_valid_i = 1'b0;
        wait_done(waits);
        check(req, "ok", int'(ok_o), int'(ok));
        check("R6", "latency", waits, tries);
        if (ok) begin
            check(req, "index", int'(index_o), idx);
            check("R2", "mask", int'(mask_o), m);
        end
        @(negedge clk);
        check("R11", "done pulse width", int'(done_o), 0);
    endtask

    task automatic release_grp(input int base, input int m);
        int waits;
        for (int s = base; s < base + (1 << m) && s < ENTRIES; s++) mdl[s] = 1'b0;
        free_valid_i = 1'b1;
        free_base_i  = IDX_W'(base);
        free_mask_i  = MASK_W'(m);
        @(negedge clk);
        free_valid_i = 1'b0;
        wait_done(waits);
        check("R9", "release latency", waits, 0);
        check("R9", "release ok", int'(ok_o), 1);
        check("R9", "release index", int'(index_o), base);
        check("R9", "release mask", int'(mask_o), m);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R11", "reset busy", int'(busy_o), 0);
        check("R11", "reset done", int'(done_o), 0);
    endtask

    task automatic t_basic();
        alloc(0, "R1");
        alloc(3, "R5");        // group of 4 at slot 0
        alloc(1, "R8");        // skips occupied slots 0..3
        alloc(5, "R5");        // group of 8 at slot 8
    endtask

    task automatic t_limit();
        max_mask_i = 3'd2;
        alloc(5, "R3");        // exponent 3 above limit 2
        alloc(2, "R3");        // table untouched by the rejection
        max_mask_i = 3'd7;
        alloc(100, "R4");
        max_mask_i = 3'd6;
        alloc(64, "R7");       // slot 0 occupied, next candidate wraps
    endtask

    task automatic t_release();
        release_grp(0, 2);
        alloc(4, "R9");        // reuses slot 0
        release_grp(60, 3);    // part lies beyond the table end
    endtask

    task automatic t_collide();
        // request and release together: release is dropped
        alloc(1, "R10", 1'b1, 8, 3);
        alloc(8, "R10");
    endtask

    task automatic t_fill();
        for (int i = 0; i < 10; i++) alloc(8, "R7");
        release_grp(0, 6);
        alloc(64, "R9");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_limit();
        t_release();
        t_collide();
        t_fill();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule